// File: doc/BRIEF.md
# Display Line Sync Generator

This block drives the horizontal sync pin of a display from the sampling-clock domain. It has two sources for that pin. The first is a free-running line-length divider that wraps once every programmed number of clocks. It issues a single-clock pulse on every line, whether or not an incoming horizontal sync exists. The second is the incoming horizontal sync itself. That signal is brought into the clock domain by a flop synchroniser and then delayed by a parameterised shift register so that it lines up with the pixel-data pipeline. On this path the output keeps the width of the incoming pulse.

A select input chooses the source. A polarity input sets the active level. Both paths run at all times. A source switch only changes which path feeds the final output flop, so the output always changes on a clock edge. The divider length comes from a term-count input. A new length is taken only at the end of the current line.

Top module: `line_sync_gen`

## Requirements
- R1: While `rst` is high at a rising edge, `sync_out` goes to the inactive level (`sync_out` = `pol_inv`), and the divider and the HS delay line are cleared.
- R2: With `src_sel` = 0 (divider source), `sync_out` is active for exactly one clock once every L rising edges. L is the latched line length. The first active cycle follows the L-th edge after reset release.
- R3: With `src_sel` = 0, `hs_in` has no effect on `sync_out`. Pulses continue when `hs_in` is held low, held high or toggled.
- R4: With `src_sel` = 1 (HS source), `sync_out` after edge k equals `pol_inv` XOR the `hs_in` value sampled at edge k-(PIPE_DLY+SYNC_STAGES). This preserves the pulse width. Before reset has drained the delay line, zeros come out.
- R5: `pol_inv` = 0 makes the active level 1. `pol_inv` = 1 makes the active level 0. The value sampled at an edge applies to the output of that edge.
- R6: A new `term_cnt` is taken only when the current line wraps (and at reset). The line in progress completes with its old length.
- R7: A `term_cnt` of 0 or 1 gives a line length of 2.
- R8: `sync_out` is a register output. A change of `src_sel` takes effect on the output of the next rising edge.
- R9: The divider keeps counting while the HS source is selected, and the HS delay line keeps shifting while the divider is selected. After a switch, the newly selected source appears in its running phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| hs_in | input | 1 | Raw incoming horizontal sync, asynchronous |
| src_sel | input | 1 | Source select: 0 divider, 1 delayed HS |
| pol_inv | input | 1 | Output polarity: 0 active high, 1 active low |
| term_cnt | input | CNT_W | Line length in clocks |
| sync_out | output | 1 | Display horizontal sync |

## Verification
The bench builds the block with CNT_W = 8, PIPE_DLY = 3 and SYNC_STAGES = 2. This gives a five-edge HS latency that is short enough to see many full HS pulses pass through in each vector, in both polarities. Short line lengths (0 to 7) put many divider wraps inside each run. This brings the clamp to 2, mid-line length changes and source switches at arbitrary divider phases within reach. The zero-depth delay variant is chosen by the generate branch but is not built by this bench.

// File: rtl/lsg_pkg.sv
package lsg_pkg;

   typedef enum logic {
      SRC_DIVIDER = 1'b0,
      SRC_HSYNC   = 1'b1
   } lsg_src_e;

   localparam int unsigned LSG_MIN_LINE = 2;

endpackage

// File: rtl/lsg_line_div.sv
module lsg_line_div #(
   parameter int unsigned CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [CNT_W-1:0] term_cnt,
   output logic             wrap_o
);
   localparam logic [CNT_W-1:0] MIN_LEN = CNT_W'(lsg_pkg::LSG_MIN_LINE);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] len_q;
   logic [CNT_W-1:0] len_in;
   logic             at_end;

   // lengths below the minimum are raised to it
   assign len_in = (term_cnt < MIN_LEN) ? MIN_LEN : term_cnt;
   assign at_end = (cnt_q == len_q - 1'b1);
   assign wrap_o = at_end;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
         len_q <= len_in;
      end else if (at_end) begin
         cnt_q <= '0;
         len_q <= len_in;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/lsg_sync.sv
module lsg_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic d_in,
   output logic d_out
);
   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk) begin
      if (rst) chain_q <= '0;
      else     chain_q <= STAGES'({chain_q, d_in});
   end

   assign d_out = chain_q[STAGES-1];
endmodule

// File: rtl/lsg_pipe_dly.sv
module lsg_pipe_dly #(
   parameter int unsigned DEPTH = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic d_in,
   output logic d_out
);
   generate
      if (DEPTH == 0) begin : g_bypass
         assign d_out = d_in;
      end else begin : g_shift
         logic [DEPTH-1:0] sr_q;
         always_ff @(posedge clk) begin
            if (rst) sr_q <= '0;
            else     sr_q <= DEPTH'({sr_q, d_in});
         end
         assign d_out = sr_q[DEPTH-1];
      end
   endgenerate
endmodule

// File: rtl/line_sync_gen.sv
module line_sync_gen #(
   parameter int unsigned CNT_W       = 12,
   parameter int unsigned PIPE_DLY    = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             hs_in,
   input  logic             src_sel,
   input  logic             pol_inv,
   input  logic [CNT_W-1:0] term_cnt,
   output logic             sync_out
);
   import lsg_pkg::*;

   generate
      if (CNT_W < 2) begin : g_bad_cnt_w
         $error("line_sync_gen: CNT_W must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("line_sync_gen: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic     div_wrap;
   logic     hs_sync;
   logic     hs_aligned;
   logic     raw_act;
   logic     out_q;
   lsg_src_e src;

   lsg_line_div #(.CNT_W(CNT_W)) div_i (
      .clk      (clk),
      .rst      (rst),
      .term_cnt (term_cnt),
      .wrap_o   (div_wrap)
   );

   lsg_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk   (clk),
      .rst   (rst),
      .d_in  (hs_in),
      .d_out (hs_sync)
   );

   lsg_pipe_dly #(.DEPTH(PIPE_DLY)) dly_i (
      .clk   (clk),
      .rst   (rst),
      .d_in  (hs_sync),
      .d_out (hs_aligned)
   );

   assign src     = lsg_src_e'(src_sel);
   assign raw_act = (src == SRC_HSYNC) ? hs_aligned : div_wrap;

   // single output flop: a source or polarity change lands on an edge
   always_ff @(posedge clk) begin
      if (rst) out_q <= pol_inv;
      else     out_q <= pol_inv ^ raw_act;
   end

   assign sync_out = out_q;
endmodule

// File: rtl/lsg_chk.sv
module lsg_chk #(
   parameter int unsigned CNT_W       = 12,
   parameter int unsigned PIPE_DLY    = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input logic             clk,
   input logic             rst,
   input logic             hs_in,
   input logic             src_sel,
   input logic             pol_inv,
   input logic [CNT_W-1:0] term_cnt,
   input logic             sync_out
);
   localparam int unsigned LAT = PIPE_DLY + SYNC_STAGES;
   localparam int unsigned RW  = $clog2(LAT + 2) + 1;

   logic          sel_q, pol_q;
   logic [RW-1:0] lo_run, hi_run;
   logic          act;

   always_ff @(posedge clk) begin
      sel_q <= src_sel;
      pol_q <= pol_inv;
      if (rst) begin
         lo_run <= '0;
         hi_run <= '0;
      end else begin
         lo_run <= hs_in ? '0 : ((lo_run > RW'(LAT)) ? lo_run : lo_run + 1'b1);
         hi_run <= !hs_in ? '0 : ((hi_run > RW'(LAT)) ? hi_run : hi_run + 1'b1);
      end
   end

   assign act = sync_out ^ pol_q;

   p_reset_idle_r1: assert property (@(posedge clk)
      rst |=> (sync_out == $past(pol_inv)));

   p_one_wide_r2: assert property (@(posedge clk) disable iff (rst)
      (!sel_q && act && !src_sel) |=> !(sync_out ^ pol_q));

   p_hs_low_r4: assert property (@(posedge clk) disable iff (rst)
      (sel_q && (lo_run > RW'(LAT))) |-> !act);

   p_hs_high_r4: assert property (@(posedge clk) disable iff (rst)
      (sel_q && (hi_run > RW'(LAT))) |-> act);
endmodule

bind line_sync_gen lsg_chk #(
   .CNT_W(CNT_W), .PIPE_DLY(PIPE_DLY), .SYNC_STAGES(SYNC_STAGES)
) chk_i (
   .clk(clk), .rst(rst), .hs_in(hs_in), .src_sel(src_sel),
   .pol_inv(pol_inv), .term_cnt(term_cnt), .sync_out(sync_out)
);

// File: tb/line_sync_gen_tb_top.sv
`timescale 1ns/1ps
module line_sync_gen_tb_top;
   localparam int unsigned CNT_W = 8;
   localparam int unsigned DLY   = 3;
   localparam int unsigned SYNC  = 2;
   localparam int unsigned LAT   = DLY + SYNC;

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic             hs_in = 1'b0;
   logic             src_sel = 1'b0;
   logic             pol_inv = 1'b0;
   logic [CNT_W-1:0] term_cnt = 8'd4;
   logic             sync_out;

   always #2.5 clk = ~clk;

   line_sync_gen #(.CNT_W(CNT_W), .PIPE_DLY(DLY), .SYNC_STAGES(SYNC)) dut_i (
      .clk(clk), .rst(rst), .hs_in(hs_in), .src_sel(src_sel),
      .pol_inv(pol_inv), .term_cnt(term_cnt), .sync_out(sync_out)
   );

   // vector: {sel, pol, term[7:0], hs_period[7:0], hs_width[7:0], cycles[7:0]}
   localparam logic [33:0] VEC [8] = '{
      {1'b0, 1'b0, 8'd4,  8'd0,  8'd0, 8'd20},  // R2 R3: no HS at all
      {1'b0, 1'b1, 8'd7,  8'd9,  8'd3, 8'd30},  // R3 R5: HS toggling, active low
      {1'b0, 1'b0, 8'd1,  8'd6,  8'd6, 8'd12},  // R7: length 1, HS held high
      {1'b0, 1'b0, 8'd0,  8'd5,  8'd2, 8'd12},  // R7: length 0
      {1'b1, 1'b0, 8'd4,  8'd10, 8'd3, 8'd40},  // R4
      {1'b1, 1'b1, 8'd4,  8'd7,  8'd1, 8'd30},  // R4 R5: single-clock HS
      {1'b1, 1'b0, 8'd5,  8'd12, 8'd9, 8'd40},  // R4: wide HS
      {1'b1, 1'b0, 8'd3,  8'd0,  8'd0, 8'd20}   // R4: HS absent, output idle
   };

   int nvec = 0;
   int nbad = 0;
   bit reported = 1'b0;

   // requirement-level model state
   int               ph = 0;
   int               lm = 2;
   logic [LAT-1:0]   hist = '0;

   function automatic int line_len(input logic [CNT_W-1:0] t);
      return (t < 2) ? 2 : int'(t);
   endfunction

   task automatic summary();
      if (!reported) begin
         reported = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      end
   endtask

   task automatic tick(input logic hs, input logic sel, input logic pol,
                       input logic [CNT_W-1:0] term, input logic rst_v,
                       input string tag);
      logic exp_v;
      logic wrap;
      hs_in = hs; src_sel = sel; pol_inv = pol; term_cnt = term; rst = rst_v;
      if (rst_v) begin
         ph = 0; lm = line_len(term); hist = '0; exp_v = pol;
      end else begin
         wrap = (ph == lm - 1);
         if (wrap) begin ph = 0; lm = line_len(term); end
         else ph = ph + 1;
         exp_v = pol ^ (sel ? hist[LAT-1] : wrap);
         hist = {hist[LAT-2:0], hs};
      end
      @(posedge clk);
      @(negedge clk);
      nvec++;
      if (sync_out !== exp_v) begin
         nbad++;
         $display("FAIL %s: sync_out=%b expected %b at %0t", tag, sync_out, exp_v, $time);
      end
   endtask

   initial begin
      #(200000 * 5);
      nbad++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      summary();
      $finish;
   end

   initial begin
      @(negedge clk);

      // table walk
      for (int v = 0; v < 8; v++) begin
         logic sel, pol, hs;
         logic [7:0] term, per, wid, ncyc;
         {sel, pol, term, per, wid, ncyc} = VEC[v];
         for (int r = 0; r < 2; r++) tick(1'b0, sel, pol, term, 1'b1, "R1 reset level");
         for (int i = 0; i < int'(ncyc); i++) begin
            hs = (per != 0) && ((i % int'(per)) < int'(wid));
            tick(hs, sel, pol, term, 1'b0, sel ? "R4 HS source" : "R2/R3 divider source");
         end
      end

      // R1: reset in mid-line with active-low polarity, then restart from zero phase
      for (int i = 0; i < 5; i++) tick(1'b1, 1'b0, 1'b1, 8'd3, 1'b0, "R2 pre-reset");
      tick(1'b1, 1'b0, 1'b1, 8'd3, 1'b1, "R1 reset mid-line");
      for (int i = 0; i < 7; i++) tick(1'b1, 1'b0, 1'b1, 8'd3, 1'b0, "R1 restart phase");

      // R6: length changed in mid-line takes effect after the wrap
      tick(1'b0, 1'b0, 1'b0, 8'd5, 1'b1, "R1 reset");
      for (int i = 0; i < 3; i++) tick(1'b0, 1'b0, 1'b0, 8'd5, 1'b0, "R6 old length");
      for (int i = 0; i < 14; i++) tick(1'b0, 1'b0, 1'b0, 8'd3, 1'b0, "R6 new length");

      // R7: length 1 then 0 while running
      for (int i = 0; i < 6; i++) tick(1'b0, 1'b0, 1'b0, 8'd1, 1'b0, "R7 length 1");
      for (int i = 0; i < 6; i++) tick(1'b0, 1'b0, 1'b0, 8'd0, 1'b0, "R7 length 0");

      // R8 R9: source toggled every 7 clocks, both paths stay in phase
      tick(1'b0, 1'b0, 1'b0, 8'd6, 1'b1, "R1 reset");
      for (int i = 0; i < 56; i++)
         tick(((i % 5) < 2), ((i / 7) % 2) == 1, 1'b0, 8'd6, 1'b0,
              ((i % 7) == 0) ? "R8 source switch" : "R9 running phase");

      // R5: polarity toggled every 5 clocks in both sources
      for (int i = 0; i < 40; i++)
         tick(((i % 6) < 3), (i >= 20), ((i / 5) % 2) == 1, 8'd4, 1'b0, "R5 polarity");

      summary();
      $finish;
   end
endmodule